// File: doc/BRIEF.md
# Bus-Mapped RAM, Parallel Port and Timer Peripheral

This block sits on an 8-bit microcontroller data bus. One select input divides its address space into two halves. With the select low, the 8-bit address reaches a 256-byte scratch RAM. With the select high, the same address reaches a small bank of six registers. Those registers hold a command/status byte, three parallel ports and a 14-bit down-counting timer.

Each port has a direction set by the command byte and an output latch, and the port lines start as inputs after reset. The timer counts pulses on a timer-tick input. It drives an active-low output for one tick period when it reaches terminal count. It can stop at that point or reload its programmed length and continue.

All logic is synchronous to one clock with an active-high synchronous reset. A bus access is one cycle with chip select and a strobe high. Read data appears on `rdata` one clock after the read strobe and holds until the next read.

Top module: `bus_ramio_timer`

## Requirements
- R1: With `io_sel`=0, a write stores `wdata` at RAM location `addr`. A read with `io_sel`=0 returns that byte on `rdata` one clock later, and all 256 locations are distinct. `rdata` changes only after a read.
- R2: With `io_sel`=1, offsets 0..5 select the registers, and a write there leaves the RAM unchanged. Writes to offsets 6..255 are ignored, and reads of them return 0x00.
- R3: A write to offset 0 sets `pa_oe` to `wdata` bit 0 and `pb_oe` to `wdata` bit 1 on the next clock. Port direction changes only through such a write.
- R4: `pc_oe` becomes 1 only when a write to offset 0 has `wdata` bits 3 and 2 both set. Any other value on those bits makes port C an input.
- R5: After reset, `pa_oe`, `pb_oe` and `pc_oe` are 0 and the port latches are 0. The timer is stopped with count 0 and mode 0, `tmr_out_n` is 1, the done flag is clear, and `rdata` is 0x00.
- R6: Offsets 1, 2 and 3 map to ports A, B and C. A write loads the port latch whatever the direction, and `*_out` shows that latch. A read returns the latch when the port is an output and the input pins when it is an input. Port C is 6 bits wide: it reads in `rdata[5:0]` with bits 7:6 returned as 0.
- R7: Offset 4 write sets length bits 7:0. Offset 5 write sets length bits 13:8 from `wdata[5:0]` and the timer mode from `wdata[7:6]`. A read of offset 4 returns current count bits 7:0, and a read of offset 5 returns {mode, count bits 13:8}.
- R8: Command bits 7:6 = 11 load the length into the count and start the timer. Each `tmr_tick` pulse while running decrements the count. A tick that finds the count at 1 or 0 is terminal count: `tmr_out_n` goes low and returns high on the next tick.
- R9: At terminal count with mode bit 0 clear, the timer stops with count 0. With mode bit 0 set, it reloads the length and keeps running.
- R10: Command bits 7:6 = 01 stop the timer at once and hold the count. Bits 7:6 = 10 make a running timer stop at its next terminal count, even in reload mode. Bits 7:6 = 00 leave the timer unchanged.
- R11: A read of offset 0 returns the done flag in bit 6, with all other bits 0, and clears the flag. Terminal count sets the flag. If terminal count and a status read fall in the same cycle, the read returns the old flag and the flag ends set.
- R12: Ticks while the timer is stopped change neither the count, the done flag nor `tmr_out_n` (except returning a low `tmr_out_n` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| io_sel | input | 1 | 0 selects RAM, 1 selects registers |
| addr | input | 8 | Byte address or register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one clock after a read |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A drives when 1 |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B drives when 1 |
| pc_in | input | 6 | Port C pins |
| pc_out | output | 6 | Port C output latch |
| pc_oe | output | 1 | Port C drives when 1 |
| tmr_tick | input | 1 | Timer count pulse, one clock wide, synchronous to clk |
| tmr_out_n | output | 1 | Active-low terminal-count pulse |

## Verification
The assertions take some properties of the inputs for granted. `tmr_tick` is a single-clock pulse synchronous to `clk`, and `rd_en` and `wr_en` are never high together with `cs`. Bus inputs do not change near the rising edge. The stimulus changes every input on the falling edge and issues exactly one access or one tick per task step. The only deliberate overlap is a status read and a terminal tick in the same cycle, which tests the flag priority of R11.

// File: rtl/ramio_pkg.sv
package ramio_pkg;
  localparam int NUM_REGS      = 6;
  localparam int MODE_W        = 2;
  localparam int STAT_DONE_BIT = 6;

  typedef enum logic [1:0] {
    TCMD_NOP     = 2'b00,
    TCMD_HALT    = 2'b01,
    TCMD_HALT_TC = 2'b10,
    TCMD_START   = 2'b11
  } tmr_cmd_e;

  typedef enum logic [2:0] {
    OFS_CMD    = 3'd0,
    OFS_PA     = 3'd1,
    OFS_PB     = 3'd2,
    OFS_PC     = 3'd3,
    OFS_CNT_LO = 3'd4,
    OFS_CNT_HI = 3'd5
  } reg_ofs_e;
endpackage

// File: rtl/ramio_sram.sv
module ramio_sram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Read-first single-port RAM, inferable as block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[a] <= d;
    if (re) q <= mem[a];
  end
endmodule

// File: rtl/ramio_port.sv
module ramio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lat_we,
  input  logic [W-1:0] lat_d,
  input  logic         dir_we,
  input  logic         dir_d,
  input  logic [W-1:0] pins,
  output logic [W-1:0] lat_q,
  output logic         oe,
  output logic [W-1:0] rd_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
      oe    <= 1'b0;
    end else begin
      if (lat_we) lat_q <= lat_d;
      if (dir_we) oe    <= dir_d;
    end
  end

  assign rd_val = oe ? lat_q : pins;
endmodule

// File: rtl/ramio_timer.sv
module ramio_timer
  import ramio_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     wdata,
  input  logic              len_lo_we,
  input  logic              len_hi_we,
  input  logic              cmd_we,
  input  tmr_cmd_e          cmd,
  input  logic              tick,
  input  logic              stat_rd,
  output logic [CNT_W-1:0]  cnt,
  output logic [MODE_W-1:0] mode,
  output logic              out_n,
  output logic              done
);
  localparam int HI_W = CNT_W - DW;

  logic [CNT_W-1:0] len;
  logic             run;
  logic             stop_pend;
  logic             at_tc;

  assign at_tc = (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      len       <= '0;
      mode      <= '0;
      cnt       <= '0;
      run       <= 1'b0;
      stop_pend <= 1'b0;
      out_n     <= 1'b1;
      done      <= 1'b0;
    end else begin
      if (len_lo_we) len[DW-1:0] <= wdata;
      if (len_hi_we) begin
        len[CNT_W-1:DW] <= wdata[HI_W-1:0];
        mode            <= wdata[DW-1 -: MODE_W];
      end

      if (stat_rd) done <= 1'b0;
      if (tick && !out_n) out_n <= 1'b1;

      if (run && tick) begin
        if (at_tc) begin
          out_n <= 1'b0;
          done  <= 1'b1;  // written after the clear: a set wins
          if (mode[0] && !stop_pend) begin
            cnt <= len;
          end else begin
            cnt       <= '0;
            run       <= 1'b0;
            stop_pend <= 1'b0;
          end
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end

      if (cmd_we) begin
        case (cmd)
          TCMD_HALT: begin
            run       <= 1'b0;
            stop_pend <= 1'b0;
          end
          TCMD_HALT_TC: begin
            if (run) stop_pend <= 1'b1;
          end
          TCMD_START: begin
            cnt       <= len;
            run       <= 1'b1;
            stop_pend <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bus_ramio_timer.sv
module bus_ramio_timer
  import ramio_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter int PC_W  = 6,
  parameter int CNT_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs,
  input  logic            io_sel,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [DW-1:0]   pa_in,
  output logic [DW-1:0]   pa_out,
  output logic            pa_oe,
  input  logic [DW-1:0]   pb_in,
  output logic [DW-1:0]   pb_out,
  output logic            pb_oe,
  input  logic [PC_W-1:0] pc_in,
  output logic [PC_W-1:0] pc_out,
  output logic            pc_oe,
  input  logic            tmr_tick,
  output logic            tmr_out_n
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic             acc_wr, acc_rd, reg_hit;
  logic [IDX_W-1:0] reg_idx;
  logic             ram_we, ram_re;
  logic             cmd_we, pa_we, pb_we, pc_we, lo_we, hi_we, stat_rd;
  logic [DW-1:0]    ram_q;
  logic [DW-1:0]    pa_rd, pb_rd;
  logic [PC_W-1:0]  pc_rd;
  logic [CNT_W-1:0] cnt;
  logic [MODE_W-1:0] mode;
  logic             done;
  logic [DW-1:0]    reg_val, reg_q;
  logic             sel_ram;

  // Access decode
  assign acc_wr  = cs && wr_en;
  assign acc_rd  = cs && rd_en;
  assign reg_hit = io_sel && (addr < AW'(NUM_REGS));
  assign reg_idx = addr[IDX_W-1:0];
  assign ram_we  = acc_wr && !io_sel;
  assign ram_re  = acc_rd && !io_sel;

  assign cmd_we  = acc_wr && reg_hit && (reg_idx == OFS_CMD);
  assign pa_we   = acc_wr && reg_hit && (reg_idx == OFS_PA);
  assign pb_we   = acc_wr && reg_hit && (reg_idx == OFS_PB);
  assign pc_we   = acc_wr && reg_hit && (reg_idx == OFS_PC);
  assign lo_we   = acc_wr && reg_hit && (reg_idx == OFS_CNT_LO);
  assign hi_we   = acc_wr && reg_hit && (reg_idx == OFS_CNT_HI);
  assign stat_rd = acc_rd && reg_hit && (reg_idx == OFS_CMD);

  ramio_sram #(.AW(AW), .DW(DW)) u_ram (
    .clk (clk),
    .we  (ram_we),
    .re  (ram_re),
    .a   (addr),
    .d   (wdata),
    .q   (ram_q)
  );

  ramio_port #(.W(DW)) u_pa (
    .clk (clk), .rst (rst),
    .lat_we (pa_we), .lat_d (wdata),
    .dir_we (cmd_we), .dir_d (wdata[0]),
    .pins (pa_in), .lat_q (pa_out), .oe (pa_oe), .rd_val (pa_rd)
  );

  ramio_port #(.W(DW)) u_pb (
    .clk (clk), .rst (rst),
    .lat_we (pb_we), .lat_d (wdata),
    .dir_we (cmd_we), .dir_d (wdata[1]),
    .pins (pb_in), .lat_q (pb_out), .oe (pb_oe), .rd_val (pb_rd)
  );

  ramio_port #(.W(PC_W)) u_pc (
    .clk (clk), .rst (rst),
    .lat_we (pc_we), .lat_d (wdata[PC_W-1:0]),
    .dir_we (cmd_we), .dir_d (&wdata[3:2]),
    .pins (pc_in), .lat_q (pc_out), .oe (pc_oe), .rd_val (pc_rd)
  );

  ramio_timer #(.DW(DW), .CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .wdata     (wdata),
    .len_lo_we (lo_we),
    .len_hi_we (hi_we),
    .cmd_we    (cmd_we),
    .cmd       (tmr_cmd_e'(wdata[DW-1 -: 2])),
    .tick      (tmr_tick),
    .stat_rd   (stat_rd),
    .cnt       (cnt),
    .mode      (mode),
    .out_n     (tmr_out_n),
    .done      (done)
  );

  // Register read mux
  always_comb begin
    reg_val = '0;
    if (reg_hit) begin
      case (reg_idx)
        OFS_CMD:    reg_val[STAT_DONE_BIT] = done;
        OFS_PA:     reg_val = pa_rd;
        OFS_PB:     reg_val = pb_rd;
        OFS_PC:     reg_val = DW'(pc_rd);
        OFS_CNT_LO: reg_val = cnt[DW-1:0];
        OFS_CNT_HI: reg_val = {mode, cnt[CNT_W-1:DW]};
        default:    reg_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= '0;
      sel_ram <= 1'b0;
    end else if (acc_rd) begin
      sel_ram <= !io_sel;
      if (io_sel) reg_q <= reg_val;
    end
  end

  assign rdata = sel_ram ? ram_q : reg_q;
endmodule

// File: rtl/bus_ramio_timer_chk.sv
module bus_ramio_timer_chk #(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int PC_W = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          cs,
  input logic          io_sel,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          pa_oe,
  input logic          pb_oe,
  input logic          pc_oe,
  input logic          tmr_tick,
  input logic          tmr_out_n
);
  logic cmd_wr;
  assign cmd_wr = cs && wr_en && io_sel && (addr == '0);

  // R5: every port leaves reset as an input
  p_reset_inputs_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pa_oe && !pb_oe && !pc_oe));

  // R3: command write sets A/B direction from bits 0 and 1
  p_ab_dir_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> (pa_oe == $past(wdata[0]) && pb_oe == $past(wdata[1])));

  // R4: port C drives only when both bits 3:2 were written as 1
  p_pc_dir_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> (pc_oe == ($past(wdata[3]) && $past(wdata[2]))));

  // R3: direction holds without a command write
  p_dir_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cmd_wr)) |-> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  // R8: the terminal pulse starts and ends only on a tick
  p_out_fall_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(tmr_out_n)) |-> $past(tmr_tick));
  p_out_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(tmr_out_n)) |-> $past(tmr_tick));

  // R1: read data changes only after a read
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cs && rd_en)) |-> $stable(rdata));
endmodule

bind bus_ramio_timer bus_ramio_timer_chk #(.DW(DW), .AW(AW), .PC_W(PC_W)) u_chk (.*);

// File: tb/bus_ramio_timer_bench.sv
`timescale 1ns/1ps
module bus_ramio_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 0, io_sel = 0, wr_en = 0, rd_en = 0, tmr_tick = 0;
  logic [7:0] addr = 0, wdata = 0, pa_in = 0, pb_in = 0;
  logic [5:0] pc_in = 0;
  logic [7:0] rdata, pa_out, pb_out;
  logic [5:0] pc_out;
  logic       pa_oe, pb_oe, pc_oe, tmr_out_n;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  bus_ramio_timer u_bus_ramio_timer (
    .clk, .rst, .cs, .io_sel, .addr, .wr_en, .rd_en, .wdata, .rdata,
    .pa_in, .pa_out, .pa_oe, .pb_in, .pb_out, .pb_oe,
    .pc_in, .pc_out, .pc_oe, .tmr_tick, .tmr_out_n
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic io, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1; io_sel = io; addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    cs = 0; wr_en = 0;
  endtask

  task automatic rd(input logic io, input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1; io_sel = io; addr = a; rd_en = 1;
    @(negedge clk);
    cs = 0; rd_en = 0;
    d = rdata;
  endtask

  task automatic tick();
    @(negedge clk); tmr_tick = 1;
    @(negedge clk); tmr_tick = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R5 pa_oe", pa_oe, 0);
    chk("R5 pb_oe", pb_oe, 0);
    chk("R5 pc_oe", pc_oe, 0);
    chk("R5 pa_out", pa_out, 0);
    chk("R5 out_n", tmr_out_n, 1);
    chk("R5 rdata", rdata, 0);
    rd(1, 8'd0, d); chk("R5 status", d, 8'h00);
    rd(1, 8'd5, d); chk("R5 count hi/mode", d, 8'h00);
  endtask

  task automatic t_ram();
    logic [7:0] d;
    for (int i = 0; i < 256; i++) wr(0, 8'(i), 8'(i) ^ 8'h5A);
    for (int i = 0; i < 256; i += 17) begin
      rd(0, 8'(i), d); chk("R1 ram readback", d, 8'(i) ^ 8'h5A);
    end
    rd(0, 8'hFF, d); chk("R1 ram top", d, 8'hA5);
    repeat (3) @(negedge clk);
    chk("R1 rdata holds", rdata, 8'hA5);
  endtask

  task automatic t_reg_space();
    logic [7:0] d;
    wr(0, 8'd1, 8'hC3);
    wr(1, 8'd1, 8'h77);
    rd(0, 8'd1, d); chk("R2 ram untouched by reg write", d, 8'hC3);
    wr(1, 8'd9, 8'hFF);
    rd(1, 8'd9, d); chk("R2 unmapped offset reads 0", d, 8'h00);
    chk("R2 unmapped write no dir", {pa_oe, pb_oe, pc_oe}, 3'b000);
    wr(1, 8'd1, 8'h00);
  endtask

  task automatic t_port_ab();
    logic [7:0] d;
    pa_in = 8'h5A; pb_in = 8'hC3;
    rd(1, 8'd1, d); chk("R6 pa input read", d, 8'h5A);
    wr(1, 8'd1, 8'h33);
    chk("R6 pa latch shown", pa_out, 8'h33);
    rd(1, 8'd1, d); chk("R6 pa still pins", d, 8'h5A);
    wr(1, 8'd0, 8'h01);
    chk("R3 pa_oe set", pa_oe, 1);
    chk("R3 pb_oe clear", pb_oe, 0);
    rd(1, 8'd1, d); chk("R6 pa output read", d, 8'h33);
    wr(1, 8'd2, 8'h96);
    wr(1, 8'd0, 8'h02);
    chk("R3 pa_oe cleared", pa_oe, 0);
    chk("R3 pb_oe set", pb_oe, 1);
    rd(1, 8'd2, d); chk("R6 pb output read", d, 8'h96);
    rd(1, 8'd1, d); chk("R6 pa back to pins", d, 8'h5A);
  endtask

  task automatic t_port_c();
    logic [7:0] d;
    pc_in = 6'h2B;
    wr(1, 8'd0, 8'h04);
    chk("R4 one bit leaves input", pc_oe, 0);
    wr(1, 8'd0, 8'h08);
    chk("R4 other bit leaves input", pc_oe, 0);
    rd(1, 8'd3, d); chk("R6 pc input read", d, 8'h2B);
    wr(1, 8'd3, 8'hFF);
    wr(1, 8'd0, 8'h0C);
    chk("R4 both bits output", pc_oe, 1);
    chk("R6 pc latch 6 bits", pc_out, 6'h3F);
    rd(1, 8'd3, d); chk("R6 pc output read upper zero", d, 8'h3F);
    wr(1, 8'd0, 8'h00);
    chk("R4 back to input", pc_oe, 0);
  endtask

  task automatic t_timer_regs();
    logic [7:0] d;
    wr(1, 8'd4, 8'hBC);
    wr(1, 8'd5, 8'h6A);
    rd(1, 8'd4, d); chk("R7 count not loaded by length write", d, 8'h00);
    wr(1, 8'd0, 8'hC0);
    rd(1, 8'd4, d); chk("R7 count lo after load", d, 8'hBC);
    rd(1, 8'd5, d); chk("R7 mode and count hi", d, 8'h6A);
    wr(1, 8'd0, 8'h40);
  endtask

  task automatic t_oneshot();
    logic [7:0] d;
    rd(1, 8'd0, d);
    wr(1, 8'd4, 8'd3); wr(1, 8'd5, 8'h00);
    wr(1, 8'd0, 8'hC0);
    tick(); tick();
    rd(1, 8'd4, d); chk("R8 decrement", d, 8'd1);
    chk("R8 out high before tc", tmr_out_n, 1);
    tick();
    chk("R8 out low at tc", tmr_out_n, 0);
    rd(1, 8'd4, d); chk("R9 one-shot count 0", d, 8'd0);
    tick();
    chk("R8 out high next tick", tmr_out_n, 1);
    tick();
    chk("R9 stays stopped", tmr_out_n, 1);
    rd(1, 8'd0, d); chk("R11 done flag", d, 8'h40);
    rd(1, 8'd0, d); chk("R11 cleared by read", d, 8'h00);
  endtask

  task automatic t_continuous();
    logic [7:0] d;
    wr(1, 8'd4, 8'd2); wr(1, 8'd5, 8'h40);
    wr(1, 8'd0, 8'hC0);
    tick(); tick();
    chk("R9 tc in reload mode", tmr_out_n, 0);
    rd(1, 8'd4, d); chk("R9 reloaded", d, 8'd2);
    tick();
    chk("R8 pulse one tick", tmr_out_n, 1);
    tick();
    chk("R9 second tc", tmr_out_n, 0);
    wr(1, 8'd0, 8'h80);
    tick();
    rd(1, 8'd4, d); chk("R10 still running after stop-at-tc", d, 8'd1);
    tick();
    chk("R10 tc reached", tmr_out_n, 0);
    rd(1, 8'd4, d); chk("R10 stopped at tc", d, 8'd0);
    tick(); tick();
    rd(1, 8'd4, d); chk("R10 no reload after stop-at-tc", d, 8'd0);
    rd(1, 8'd0, d);
  endtask

  task automatic t_halt();
    logic [7:0] d;
    wr(1, 8'd4, 8'd10); wr(1, 8'd5, 8'h00);
    wr(1, 8'd0, 8'hC0);
    tick(); tick(); tick();
    wr(1, 8'd0, 8'h40);
    tick(); tick();
    rd(1, 8'd4, d); chk("R10 halt holds count", d, 8'd7);
    chk("R12 stopped ticks no pulse", tmr_out_n, 1);
    rd(1, 8'd0, d); chk("R12 stopped ticks no done", d, 8'h00);
    wr(1, 8'd0, 8'hC0);
    tick();
    wr(1, 8'd0, 8'h00);
    tick();
    rd(1, 8'd4, d); chk("R10 nop command keeps counting", d, 8'd8);
    wr(1, 8'd0, 8'h40);
  endtask

  task automatic t_done_priority();
    logic [7:0] d;
    wr(1, 8'd4, 8'd1); wr(1, 8'd5, 8'h00);
    wr(1, 8'd0, 8'hC0);
    @(negedge clk);
    tmr_tick = 1; cs = 1; io_sel = 1; addr = 8'd0; rd_en = 1;
    @(negedge clk);
    tmr_tick = 0; cs = 0; rd_en = 0;
    chk("R11 same-cycle read sees old flag", rdata, 8'h00);
    chk("R8 tc same cycle", tmr_out_n, 0);
    rd(1, 8'd0, d); chk("R11 set wins over clear", d, 8'h40);
    rd(1, 8'd0, d); chk("R11 cleared after", d, 8'h00);
  endtask

  task automatic t_idle_ticks();
    logic [7:0] d;
    do_reset();
    tick(); tick();
    chk("R12 idle out_n", tmr_out_n, 1);
    rd(1, 8'd4, d); chk("R12 idle count", d, 8'h00);
    rd(1, 8'd0, d); chk("R12 idle done", d, 8'h00);
  endtask

  initial begin
    t_reset();
    t_ram();
    t_reg_space();
    t_port_ab();
    t_port_c();
    t_timer_regs();
    t_oneshot();
    t_continuous();
    t_halt();
    t_done_priority();
    t_idle_ticks();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule